// File: doc/BRIEF.md
# Two-Stage Thermometer-to-Binary Encoder

This block takes the parallel word from a bank of flash-converter comparators, where the number of set bits gives the input level, and turns it into a binary count. The work is split in two. First, an edge detector finds where the word changes from ones to zeros and produces a word with a single active line at that position. That word is registered. Second, one balanced OR tree per output bit gathers every active line whose index has that bit set, and the result is registered as the output.

The vector is treated as if it had a fixed 1 below its lowest bit and a fixed 0 above its highest bit. An all-clear word therefore gives 0, and an all-set word gives the largest code. A sample is taken on every clock. The valid strobe follows it through both registers, so a result appears exactly two clocks after its sample. If the intermediate word does not have exactly one active line, which happens when a comparator bubble breaks the thermometer pattern, an error flag is raised on the same cycle as the affected result. That result is the bitwise OR of the indices of all active lines.

Top module: `therm_bin_encoder`

## Requirements
- R1: A legal thermometer input with k bits set (bits 0..k-1) produces bin_out = k.
- R2: An all-zero input produces bin_out = 0 with code_err = 0.
- R3: An all-one input produces bin_out = 2^OUT_W - 1 (63 by default) with code_err = 0.
- R4: An input that is not a thermometer pattern, i.e. it has a set bit above a clear bit, produces code_err = 1 on the cycle its result is presented.
- R5: For such an input the result is the bitwise OR of every boundary index k for which input bit k-1 (taken as 1 for k = 0) is set and input bit k (taken as 0 for k = THERM_W) is clear.
- R6: A legal thermometer input produces code_err = 0.
- R7: A sample applied before clock edge n appears on the outputs after edge n+1, and not after edge n. out_vld is low for the first two edges after reset is released and high from then on.
- R8: While the synchronous active-high reset rst is sampled high, bin_out, code_err and out_vld are cleared at the next edge.
- R9: The intermediate one-hot register holds exactly one active line after any legal input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| therm_in | input | THERM_W (63) | Comparator thermometer word, bit 0 lowest threshold |
| bin_out | output | OUT_W (6) | Registered binary result |
| out_vld | output | 1 | Result valid, two clocks after the sample |
| code_err | output | 1 | Intermediate word was not one-hot for this result |

## Verification
The hardest case to reach from the ports is a word with several boundaries, where R5 requires the output to be the OR of several indices rather than any single index. The bench builds such words on purpose: isolated set bits above clear bits, a lone top bit, and a single bubble flipped into every legal level. Their expected OR values are worked out by hand or computed from the boundary definition. A sweep of all legal levels against a population count covers the normal path. A back-to-back transition checks that the result does not appear one clock too early.

// File: rtl/therm_pkg.sv
package therm_pkg;
    // Index of the m-th one-hot line whose index has bit b set:
    // insert a 1 at position b into the binary value m.
    function automatic int set_bit_line(input int b, input int m);
        int lo;
        int hi;
        lo = m & ((1 << b) - 1);
        hi = (m >> b) << (b + 1);
        return hi | (1 << b) | lo;
    endfunction
endpackage

// File: rtl/or_tree.sv
module or_tree #(
    parameter int W = 32
) (
    input  logic [W-1:0] leaves,
    output logic         root
);
    localparam int HALF = W / 2;
    generate
        if (W == 1) begin : g_leaf
            assign root = leaves[0];
        end else begin : g_split
            logic left_or;
            logic right_or;
            or_tree #(.W(HALF)) u_lo (
                .leaves(leaves[HALF-1:0]),
                .root  (left_or)
            );
            or_tree #(.W(W - HALF)) u_hi (
                .leaves(leaves[W-1:HALF]),
                .root  (right_or)
            );
            assign root = left_or | right_or;
        end
    endgenerate
endmodule

// File: rtl/therm_boundary.sv
module therm_boundary #(
    parameter int THERM_W = 63,
    parameter int LINES   = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THERM_W-1:0] therm_in,
    output logic [LINES-1:0]   onehot_q
);
    // Extended word: implied 1 below bit 0, implied 0 above the top bit.
    logic [THERM_W+1:0] ext;
    logic [LINES-1:0]   onehot_d;

    assign ext = {1'b0, therm_in, 1'b1};

    generate
        for (genvar k = 0; k < LINES; k++) begin : g_line
            if (k <= THERM_W) begin : g_real
                assign onehot_d[k] = ext[k] & ~ext[k+1];
            end else begin : g_pad
                assign onehot_d[k] = 1'b0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) onehot_q <= '0;
        else     onehot_q <= onehot_d;
    end

    // A legal thermometer word plus one is a power of two.
    assert_onehot_legal_R9: assert property (@(posedge clk) disable iff (rst)
        ((({1'b0, therm_in} + 1'b1) & {1'b0, therm_in}) == '0)
        |=> ($countones(onehot_q) == 1));
endmodule

// File: rtl/onehot_or_stage.sv
module onehot_or_stage
    import therm_pkg::*;
#(
    parameter int LINES = 64,
    parameter int OUT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] onehot_q,
    output logic [OUT_W-1:0] bin_q,
    output logic             err_q
);
    localparam int PER_BIT = LINES / 2;

    logic [OUT_W-1:0] bin_d;
    logic             none_set;
    logic             many_set;

    generate
        for (genvar b = 0; b < OUT_W; b++) begin : g_bit
            logic [PER_BIT-1:0] sel;
            for (genvar m = 0; m < PER_BIT; m++) begin : g_gather
                assign sel[m] = onehot_q[set_bit_line(b, m)];
            end
            or_tree #(.W(PER_BIT)) u_tree (
                .leaves(sel),
                .root  (bin_d[b])
            );
        end
    endgenerate

    assign none_set = ~|onehot_q;
    assign many_set = |(onehot_q & (onehot_q - 1'b1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q <= '0;
            err_q <= 1'b0;
        end else begin
            bin_q <= bin_d;
            err_q <= none_set | many_set;
        end
    end

    assert_err_on_bad_word_R4: assert property (@(posedge clk) disable iff (rst)
        ($countones(onehot_q) != 1) |=> err_q);
endmodule

// File: rtl/therm_bin_encoder.sv
module therm_bin_encoder #(
    parameter int THERM_W = 63,
    parameter int OUT_W   = $clog2(THERM_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THERM_W-1:0] therm_in,
    output logic [OUT_W-1:0]   bin_out,
    output logic               out_vld,
    output logic               code_err
);
    localparam int LINES = 1 << OUT_W;

    logic [LINES-1:0] onehot_q;
    logic [1:0]       vld_pipe;

    therm_boundary #(.THERM_W(THERM_W), .LINES(LINES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .therm_in(therm_in),
        .onehot_q(onehot_q)
    );

    onehot_or_stage #(.LINES(LINES), .OUT_W(OUT_W)) u_tree (
        .clk     (clk),
        .rst     (rst),
        .onehot_q(onehot_q),
        .bin_q   (bin_out),
        .err_q   (code_err)
    );

    always_ff @(posedge clk) begin
        if (rst) vld_pipe <= 2'b00;
        else     vld_pipe <= {vld_pipe[0], 1'b1};
    end
    assign out_vld = vld_pipe[1];

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!out_vld && !code_err && bin_out == '0));

    assert_zero_code_R2: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(therm_in, 2) == '0) |-> (bin_out == '0 && !code_err));

    assert_full_code_R3: assert property (@(posedge clk) disable iff (rst)
        (out_vld && $past(therm_in, 2) == '1) |-> (bin_out == '1 && !code_err));

    assert_valid_stays_R7: assert property (@(posedge clk) disable iff (rst)
        out_vld |=> out_vld);
endmodule

// File: tb/therm_bin_encoder_bench.sv
module therm_bin_encoder_bench;
    localparam int TW = 63;
    localparam int BW = 6;
    localparam int NV = 8;

    typedef struct packed {
        logic [TW-1:0] word;
        logic [BW-1:0] bin;
        logic          err;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{63'h0,                 6'd0,  1'b0},  // R2
        '{{63{1'b1}},            6'd63, 1'b0},  // R3
        '{63'h1,                 6'd1,  1'b0},  // R1
        '{63'h7,                 6'd3,  1'b0},  // R1
        '{63'hFFFF_FFFF,         6'd32, 1'b0},  // R1
        '{63'h5,                 6'd3,  1'b1},  // R5: boundaries 1 and 3
        '{63'h2,                 6'd2,  1'b1},  // R5: boundaries 0 and 2
        '{63'h1 << 62,           6'd63, 1'b1}   // R5: boundaries 0 and 63
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] therm_in = '0;
    logic [BW-1:0] bin_out;
    logic          out_vld;
    logic          code_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    therm_bin_encoder u_therm_bin_encoder (
        .clk     (clk),
        .rst     (rst),
        .therm_in(therm_in),
        .bin_out (bin_out),
        .out_vld (out_vld),
        .code_err(code_err)
    );

    task automatic check(input string req, input logic [BW-1:0] got_b, input logic [BW-1:0] exp_b,
                         input logic got_e, input logic exp_e, input logic got_v);
        checks++;
        if (got_b !== exp_b || got_e !== exp_e || got_v !== 1'b1) begin
            errors++;
            $display("FAIL %s: bin=%0d err=%0b vld=%0b, expected bin=%0d err=%0b vld=1",
                     req, got_b, got_e, got_v, exp_b, exp_e);
        end
    endtask

    task automatic run_word(input logic [TW-1:0] w, input logic [BW-1:0] eb,
                            input logic ee, input string req);
        @(negedge clk) therm_in = w;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, bin_out, eb, code_err, ee, out_vld);
    endtask

    initial begin
        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (bin_out !== '0 || code_err !== 1'b0 || out_vld !== 1'b0) begin
            errors++;
            $display("FAIL R8: bin=%0d err=%0b vld=%0b, expected 0 0 0", bin_out, code_err, out_vld);
        end
        // R7: valid rises on the second edge after release
        therm_in = 63'h3;
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        checks++;
        if (out_vld !== 1'b0) begin
            errors++;
            $display("FAIL R7: vld=%0b after one edge, expected 0", out_vld);
        end
        @(posedge clk); @(negedge clk);
        check("R7", bin_out, 6'd2, code_err, 1'b0, out_vld);

        // Table walk (R1 R2 R3 R5, with R4 for flagged rows)
        for (int i = 0; i < NV; i++) begin
            run_word(VECS[i].word, VECS[i].bin, VECS[i].err, "R1/R5 table");
        end

        // R1 R6: every legal level against a population count
        for (int k = 0; k <= TW; k++) begin
            logic [TW-1:0] w;
            w = (k == TW) ? {TW{1'b1}} : ((63'h1 << k) - 63'h1);
            run_word(w, BW'($countones(w)), 1'b0, "R1 R6 sweep");
        end

        // R4: single bubble (clear one bit two below the boundary)
        for (int k = 2; k <= TW; k++) begin
            logic [TW-1:0] w;
            w = (k == TW) ? {TW{1'b1}} : ((63'h1 << k) - 63'h1);
            w[k-2] = 1'b0;
            @(negedge clk) therm_in = w;
            @(posedge clk); @(posedge clk); @(negedge clk);
            checks++;
            if (code_err !== 1'b1) begin
                errors++;
                $display("FAIL R4: level %0d bubble err=%0b, expected 1", k, code_err);
            end
        end

        // R7: back-to-back, result must not appear after one edge
        run_word(63'hF, 6'd4, 1'b0, "R7 setup");
        @(negedge clk) therm_in = 63'h3FF;
        @(posedge clk); @(negedge clk);
        check("R7 early", bin_out, 6'd4, code_err, 1'b0, out_vld);
        @(posedge clk); @(negedge clk);
        check("R7 late", bin_out, 6'd10, code_err, 1'b0, out_vld);

        // R8: reset mid-stream
        @(negedge clk) rst = 1'b1;
        @(posedge clk); @(negedge clk);
        checks++;
        if (bin_out !== '0 || code_err !== 1'b0 || out_vld !== 1'b0) begin
            errors++;
            $display("FAIL R8: bin=%0d err=%0b vld=%0b, expected 0 0 0", bin_out, code_err, out_vld);
        end
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule